// File: doc/BRIEF.md
# Queue Doorbell Word Formatter

This block turns a doorbell request (queue kind, 24-bit queue number, 32-bit tail pointer) into one 64-bit write to a doorbell page. It picks the field layout and the offset within the page from the queue kind. It fills in the constant fields that each kind needs. It then presents the write on a simple address/data/valid/ready request port. Three kinds are served: send, receive and completion. A request of any other kind is answered with a one-cycle error pulse and no write is made.

The notification must never reach the device ahead of the queue entries it announces. For this reason the formatted write waits in a holding register until the `prior_done` input reports that all earlier data writes have finished. Only one request is in flight at a time. The request port stays not-ready from the moment a valid request is taken until its write has been accepted downstream.

Top module: `qdb_formatter`

## Requirements
- R1: After reset `req_ready` is 1, and both `wr_valid` and `err_pulse` are 0.
- R2: Kind code 1 (send) produces `wr_addr` = PAGE_BASE + 0x000 and `wr_data` = {tail[31:0], 8'h00, qid[23:0]}.
- R3: Kind code 2 (receive) produces `wr_addr` = PAGE_BASE + 0x400 and `wr_data` = {tail[31:0], 8'h01, qid[23:0]}, so the entry-count field in bits 31:24 is 1.
- R4: Kind code 3 (completion) produces `wr_addr` = PAGE_BASE + 0x800 and `wr_data` = {1'b1, tail[30:0], 8'h00, qid[23:0]}. Bit 63 is the arm flag and tail bit 31 is dropped.
- R5: A request with a kind code of 0 or 4 to 15 makes `err_pulse` high for exactly the one cycle after it is taken. It makes no write, and `req_ready` stays 1.
- R6: `wr_valid` rises only in the cycle after `prior_done` was sampled high while a write was held. While `prior_done` stays low, `wr_valid` stays 0.
- R7: Once `wr_valid` is 1, it stays 1, and `wr_addr` and `wr_data` stay unchanged, until a cycle with `wr_ready` high.
- R8: `req_ready` is 0 from the cycle after a valid-kind request is taken until the cycle after its write is accepted. It is never 1 while `wr_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Doorbell request present |
| req_ready | output | 1 | Block can take a request |
| req_kind | input | 4 | Queue kind: 1 send, 2 receive, 3 completion |
| req_qid | input | 24 | Queue number |
| req_tail | input | 32 | Tail pointer |
| prior_done | input | 1 | All earlier data writes have completed |
| wr_valid | output | 1 | Doorbell write presented |
| wr_ready | input | 1 | Downstream accepts the write |
| wr_addr | output | 32 | Write address in the doorbell page |
| wr_data | output | 64 | Doorbell word |
| err_pulse | output | 1 | One-cycle flag for an unsupported kind |

## Verification
A request taken at clock edge k moves the write into the holding state at k. If `prior_done` is high, the write appears on the port after edge k+1. The error pulse for a bad kind appears after edge k and is gone after k+1. The bench drives inputs and samples outputs on the falling edge. Each task checks at the falling edge that follows the rising edge where the result is due. Tasks also check the falling edges in between, to show that nothing appears early or stays too long. For ordering, `prior_done` is held low for several cycles with `wr_valid` checked low at each one. The write is then expected one edge after `prior_done` rises.

// File: rtl/qdb_pkg.sv
// Shared constants and types for the doorbell formatter.
// Assumes a 64-bit doorbell word split as tail / middle byte / queue id.
package qdb_pkg;
    localparam int ID_W   = 24;
    localparam int MID_W  = 8;
    localparam int TAIL_W = 32;
    localparam int WORD_W = TAIL_W + MID_W + ID_W;
    localparam int KIND_W = 4;
    localparam int OFS_W  = 12;

    // queue kind encodings
    localparam logic [KIND_W-1:0] KIND_SEND  = 4'd1;
    localparam logic [KIND_W-1:0] KIND_RECV  = 4'd2;
    localparam logic [KIND_W-1:0] KIND_COMPL = 4'd3;

    // per-kind offsets inside the doorbell page
    localparam logic [OFS_W-1:0] OFS_SEND  = 12'h000;
    localparam logic [OFS_W-1:0] OFS_RECV  = 12'h400;
    localparam logic [OFS_W-1:0] OFS_COMPL = 12'h800;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_ISSUE = 2'd2
    } qdb_state_e;
endpackage

// File: rtl/qdb_encode.sv
// Combinational encoder: builds the doorbell word and page offset for one
// request. Assumes inputs are stable while the request is offered.
module qdb_encode
    import qdb_pkg::*;
(
    input  logic [KIND_W-1:0] kind,
    input  logic [ID_W-1:0]   qid,
    input  logic [TAIL_W-1:0] tail,
    output logic              kind_ok,
    output logic [OFS_W-1:0]  ofs,
    output logic [WORD_W-1:0] word
);
    // select layout, constants and offset from the queue kind
    always_comb begin
        kind_ok = 1'b1;
        ofs     = OFS_SEND;
        word    = {tail, MID_W'(0), qid};
        case (kind)
            KIND_SEND: begin
                ofs  = OFS_SEND;
                word = {tail, MID_W'(0), qid};
            end
            KIND_RECV: begin
                ofs  = OFS_RECV;
                word = {tail, MID_W'(1), qid};
            end
            KIND_COMPL: begin
                ofs  = OFS_COMPL;
                word = {1'b1, tail[TAIL_W-2:0], MID_W'(0), qid};
            end
            default: begin
                kind_ok = 1'b0;
                word    = '0;
            end
        endcase
    end
endmodule

// File: rtl/qdb_issue.sv
// Holding stage: keeps one formatted write, waits for earlier data writes
// to drain, then presents it until accepted. Assumes load only when idle.
module qdb_issue
    import qdb_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [WORD_W-1:0] load_word,
    input  logic              prior_done,
    input  logic              wr_ready,
    output logic              idle,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);
    qdb_state_e state;

    // sequence idle -> hold (wait for drain) -> issue (wait for accept)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE:  if (load) state <= ST_HOLD;
                ST_HOLD:  if (prior_done) state <= ST_ISSUE;
                ST_ISSUE: if (wr_ready) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // capture the formatted write when a request is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            wr_data <= '0;
        end else if (load && state == ST_IDLE) begin
            wr_addr <= load_addr;
            wr_data <= load_word;
        end
    end

    assign idle     = (state == ST_IDLE);
    assign wr_valid = (state == ST_ISSUE);

    // R7
    hold_until_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R6
    drain_before_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(prior_done));
endmodule

// File: rtl/qdb_formatter.sv
// Doorbell formatter top: takes one request at a time, encodes it, flags
// unsupported kinds, and issues the write behind earlier data writes.
// Assumes prior_done is driven by the data-write path of the same clock.
module qdb_formatter
    import qdb_pkg::*;
#(
    parameter int               ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] PAGE_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_kind,
    input  logic [23:0]       req_qid,
    input  logic [31:0]       req_tail,
    input  logic              prior_done,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [63:0]       wr_data,
    output logic              err_pulse
);
    logic              kind_ok;
    logic [OFS_W-1:0]  ofs;
    logic [WORD_W-1:0] word;
    logic              idle;
    logic              take;

    qdb_encode u_encode (
        .kind    (req_kind),
        .qid     (req_qid),
        .tail    (req_tail),
        .kind_ok (kind_ok),
        .ofs     (ofs),
        .word    (word)
    );

    assign req_ready = idle;
    assign take      = req_valid && idle;

    qdb_issue #(.ADDR_W(ADDR_W)) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (take && kind_ok),
        .load_addr  (PAGE_BASE + ADDR_W'(ofs)),
        .load_word  (word),
        .prior_done (prior_done),
        .wr_ready   (wr_ready),
        .idle       (idle),
        .wr_valid   (wr_valid),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );

    // raise a one-cycle error for a taken request of unsupported kind
    always_ff @(posedge clk) begin
        if (!rst_n) err_pulse <= 1'b0;
        else        err_pulse <= take && !kind_ok;
    end

    // R5
    bad_kind_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !wr_valid && req_ready);

    // R5
    err_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |=> !err_pulse);

    // R8
    busy_while_issuing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !req_ready);

    // R4
    compl_arm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_addr == PAGE_BASE + ADDR_W'(OFS_COMPL) |-> wr_data[63]);
endmodule

// File: tb/qdb_formatter_bench.sv
module qdb_formatter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_kind = '0;
    logic [23:0] req_qid = '0;
    logic [31:0] req_tail = '0;
    logic        prior_done = 1'b1;
    logic        wr_valid;
    logic        wr_ready = 1'b0;
    logic [31:0] wr_addr;
    logic [63:0] wr_data;
    logic        err_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    qdb_formatter u_qdb_formatter (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_qid(req_qid), .req_tail(req_tail),
        .prior_done(prior_done), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_addr(wr_addr), .wr_data(wr_data), .err_pulse(err_pulse)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // expected word per the requirements
    function automatic logic [63:0] exp_word(input logic [3:0] k, input logic [23:0] id,
                                              input logic [31:0] t);
        case (k)
            4'd1:    return {t, 8'h00, id};
            4'd2:    return {t, 8'h01, id};
            default: return {1'b1, t[30:0], 8'h00, id};
        endcase
    endfunction

    function automatic logic [31:0] exp_addr(input logic [3:0] k);
        case (k)
            4'd1:    return 32'h000;
            4'd2:    return 32'h400;
            default: return 32'h800;
        endcase
    endfunction

    task automatic offer(input logic [3:0] k, input logic [23:0] id, input logic [31:0] t);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_qid = id; req_tail = t;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 req_ready", 64'(req_ready), 64'd1);
        check("R1 wr_valid", 64'(wr_valid), 64'd0);
        check("R1 err_pulse", 64'(err_pulse), 64'd0);
    endtask

    // valid kind with drain already done; write held two cycles before accept
    task automatic t_write(input string req, input logic [3:0] k, input logic [23:0] id,
                           input logic [31:0] t);
        prior_done = 1'b1; wr_ready = 1'b0;
        offer(k, id, t);
        check({req, " R8 busy after take"}, 64'(req_ready), 64'd0);
        check({req, " R6 not yet valid"}, 64'(wr_valid), 64'd0);
        @(negedge clk);
        check({req, " valid"}, 64'(wr_valid), 64'd1);
        check({req, " addr"}, 64'(wr_addr), 64'(exp_addr(k)));
        check({req, " data"}, wr_data, exp_word(k, id, t));
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check({req, " R7 hold valid"}, 64'(wr_valid), 64'd1);
            check({req, " R7 hold data"}, wr_data, exp_word(k, id, t));
            check({req, " R7 hold addr"}, 64'(wr_addr), 64'(exp_addr(k)));
        end
        wr_ready = 1'b1;
        @(negedge clk);
        wr_ready = 1'b0;
        check({req, " R8 released"}, 64'(req_ready), 64'd1);
        check({req, " R7 dropped"}, 64'(wr_valid), 64'd0);
    endtask

    task automatic t_order;
        prior_done = 1'b0; wr_ready = 1'b1;
        offer(4'd1, 24'h00ABCD, 32'h0000_0040);
        for (int i = 0; i < 5; i++) begin
            check("R6 wait drain", 64'(wr_valid), 64'd0);
            @(negedge clk);
        end
        check("R6 wait drain", 64'(wr_valid), 64'd0);
        prior_done = 1'b1;
        @(negedge clk);
        check("R6 issued after drain", 64'(wr_valid), 64'd1);
        check("R6 data", wr_data, exp_word(4'd1, 24'h00ABCD, 32'h0000_0040));
        @(negedge clk);
        wr_ready = 1'b0;
        check("R8 back to idle", 64'(req_ready), 64'd1);
    endtask

    task automatic t_bad(input logic [3:0] k);
        prior_done = 1'b1; wr_ready = 1'b1;
        offer(k, 24'h123456, 32'hDEAD_BEEF);
        check("R5 err high", 64'(err_pulse), 64'd1);
        check("R5 still ready", 64'(req_ready), 64'd1);
        check("R5 no write", 64'(wr_valid), 64'd0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R5 err gone", 64'(err_pulse), 64'd0);
            check("R5 no write later", 64'(wr_valid), 64'd0);
        end
        wr_ready = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write("R2 send", 4'd1, 24'hA1B2C3, 32'h1234_5678);
        t_write("R2 send", 4'd1, 24'hFFFFFF, 32'hFFFF_FFFF);
        t_write("R3 recv", 4'd2, 24'h000010, 32'h0000_0200);
        t_write("R3 recv", 4'd2, 24'h5A5A5A, 32'h8000_0001);
        t_write("R4 compl", 4'd3, 24'h000007, 32'h8000_0005);
        t_write("R4 compl", 4'd3, 24'h3C3C3C, 32'h7000_0001);
        t_order();
        t_bad(4'd0);
        t_bad(4'd4);
        t_bad(4'd15);
        t_write("R2 after error", 4'd1, 24'h000001, 32'h0000_0001);
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule